// File: doc/BRIEF.md
# Stream-Tagged Set-Associative Translation Cache

This block is a small set-associative translation cache for the device side of an I/O memory management unit. Every entry records the stream ID of the requesting device, a substream ID, a virtual page number and the physical page it maps to. A device-side agent issues lookups on a request port and installs new translations on a fill port. Fills choose their set from the low bits of the virtual page number.

When software changes the configuration of a stream, cached translations derived from the old configuration must go. A command port accepts three invalidation kinds. The first removes the entries of one stream/substream pair, searching only the set picked by XOR of the two IDs. The second removes every entry of one stream, walking all sets one per cycle. The third empties the whole cache. While a command is in progress the block reports busy and holds off lookups and fills, so no stale translation can be returned. A one-cycle done pulse marks completion.

Top module: `stream_tlb`

## Requirements
- R1: After reset no entry is valid, `inv_busy_o` and `inv_done_o` are 0, both ready outputs are 1, and every lookup misses.
- R2: A fill goes to set `fl_va_i[SET_W-1:0]`. If a valid entry there already holds the same stream ID, substream ID and virtual page, that way is rewritten. Otherwise the lowest-numbered invalid way is used. If the set is full, the last way (index NUM_WAYS-1) is replaced. At most one way of a set ever matches a lookup.
- R3: An accepted lookup answers one cycle later with `lk_resp_valid_o`=1. `lk_hit_o` is 1 only when a valid entry in set `lk_va_i[SET_W-1:0]` matches stream ID, substream ID and virtual page. On a hit `lk_pa_o` is that entry's physical page; on a miss it is 0.
- R4: While `inv_busy_o` is 1, `lk_ready_o` and `fl_ready_o` are 0. Lookups and fills offered then are not accepted, so no response appears and no entry changes.
- R5: A command is taken when `inv_valid_i` is 1 and `inv_busy_o` is 0. `inv_op_i` is encoded as 2'b01 stream+substream, 2'b10 stream, 2'b11 all. 2'b00 is a no-op: busy and done stay 0 and no entry changes.
- R6: A stream+substream command keeps busy high for one cycle. It clears, in set `(sid ^ ssid)` modulo NUM_SETS only, each valid way whose stream ID and substream ID both match. Matching entries held in other sets remain valid.
- R7: A stream command keeps busy high for NUM_SETS cycles, visiting sets 0 upward, one per cycle. It clears every entry with that stream ID, whatever its substream ID, and leaves other streams' entries valid.
- R8: An all command keeps busy high for one cycle and clears every entry.
- R9: `inv_done_o` is 1 for exactly one cycle: the first cycle after busy falls at the end of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_sid_i | input | SID_W | Lookup stream ID |
| lk_ssid_i | input | SSID_W | Lookup substream ID |
| lk_va_i | input | VA_W | Lookup virtual page |
| lk_ready_o | output | 1 | Lookup can be accepted |
| lk_resp_valid_o | output | 1 | Lookup response valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | PA_W | Physical page on hit, else 0 |
| fl_valid_i | input | 1 | Fill request |
| fl_sid_i | input | SID_W | Fill stream ID |
| fl_ssid_i | input | SSID_W | Fill substream ID |
| fl_va_i | input | VA_W | Fill virtual page |
| fl_pa_i | input | PA_W | Fill physical page |
| fl_ready_o | output | 1 | Fill can be accepted |
| inv_valid_i | input | 1 | Invalidation command request |
| inv_op_i | input | 2 | Command kind |
| inv_sid_i | input | SID_W | Command stream ID |
| inv_ssid_i | input | SSID_W | Command substream ID |
| inv_busy_o | output | 1 | Command in progress |
| inv_done_o | output | 1 | Command completed, one-cycle pulse |

## Verification
The in-RTL assertions check on every cycle that no lookup response follows a busy cycle, that a miss carries a zero page, that no set ever has two ways matching one lookup, that each command kind clears the ways it targets and spares the others in the set it visits, and that done is a single-cycle pulse following busy. Only the bench's scenarios show the placement order of fills, eviction of the last way, survival of a matching stream/substream entry in a set the XOR does not select, the exact busy lengths of each command kind, and the no-op encoding.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
  typedef enum logic [1:0] {
    INV_NONE     = 2'b00,
    INV_SID_SSID = 2'b01,
    INV_SID      = 2'b10,
    INV_ALL      = 2'b11
  } inv_op_e;
endpackage

// File: rtl/stlb_inv_ctrl.sv
module stlb_inv_ctrl
  import stlb_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int SID_W    = 8,
  parameter int SSID_W   = 8,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [SID_W-1:0]  cmd_sid_i,
  input  logic [SSID_W-1:0] cmd_ssid_i,
  output logic              busy_o,
  output logic              done_o,
  output inv_op_e           clr_op_o,
  output logic [SET_W-1:0]  clr_set_o,
  output logic [SID_W-1:0]  clr_sid_o,
  output logic [SSID_W-1:0] clr_ssid_o
);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  logic              busy_q, done_q;
  inv_op_e           op_q;
  logic [SET_W-1:0]  idx_q;
  logic [SID_W-1:0]  sid_q;
  logic [SSID_W-1:0] ssid_q;
  inv_op_e           op_in;
  logic [SET_W-1:0]  xor_set;
  logic              accept;

  assign op_in   = inv_op_e'(cmd_op_i);
  assign xor_set = cmd_sid_i[SET_W-1:0] ^ cmd_ssid_i[SET_W-1:0];
  assign accept  = cmd_valid_i && !busy_q && (op_in != INV_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= INV_NONE;
      idx_q  <= '0;
      sid_q  <= '0;
      ssid_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_in;
        sid_q  <= cmd_sid_i;
        ssid_q <= cmd_ssid_i;
        idx_q  <= (op_in == INV_SID_SSID) ? xor_set : '0;
      end else if (busy_q) begin
        if (op_q == INV_SID && idx_q != LAST_SET) begin
          idx_q <= idx_q + 1'b1;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign clr_op_o   = op_q;
  assign clr_set_o  = idx_q;
  assign clr_sid_o  = sid_q;
  assign clr_ssid_o = ssid_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q) && !busy_q)); // R9
  AST_SWEEP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && op_q == INV_SID && idx_q != LAST_SET) |=> (busy_q && idx_q == $past(idx_q) + 1'b1)); // R7
  AST_SHORT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && op_q != INV_SID) |=> !busy_q); // R6
endmodule

// File: rtl/stlb_set.sv
module stlb_set
  import stlb_pkg::*;
#(
  parameter int NUM_WAYS = 2,
  parameter int SID_W    = 8,
  parameter int SSID_W   = 8,
  parameter int VA_W     = 12,
  parameter int PA_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fl_en_i,
  input  logic [SID_W-1:0]  fl_sid_i,
  input  logic [SSID_W-1:0] fl_ssid_i,
  input  logic [VA_W-1:0]   fl_va_i,
  input  logic [PA_W-1:0]   fl_pa_i,
  input  logic [SID_W-1:0]  lk_sid_i,
  input  logic [SSID_W-1:0] lk_ssid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_pa_o,
  input  logic              clr_en_i,
  input  logic              clr_sel_i,
  input  inv_op_e           clr_op_i,
  input  logic [SID_W-1:0]  clr_sid_i,
  input  logic [SSID_W-1:0] clr_ssid_i
);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  logic [NUM_WAYS-1:0] valid_q;
  logic [SID_W-1:0]    sid_q  [NUM_WAYS];
  logic [SSID_W-1:0]   ssid_q [NUM_WAYS];
  logic [VA_W-1:0]     va_q   [NUM_WAYS];
  logic [PA_W-1:0]     pa_q   [NUM_WAYS];

  logic [NUM_WAYS-1:0] hit_vec, clr_vec;
  logic [WAY_W-1:0]    fill_way;
  logic                fill_found;

  always_comb begin
    lk_pa_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hit_vec[w] = valid_q[w] && sid_q[w] == lk_sid_i && ssid_q[w] == lk_ssid_i
                   && va_q[w] == lk_va_i;
      if (hit_vec[w]) lk_pa_o = lk_pa_o | pa_q[w];
    end
  end
  assign lk_hit_o = |hit_vec;

  // replacement: same tag, else lowest invalid, else last way
  always_comb begin
    fill_way   = WAY_W'(NUM_WAYS - 1);
    fill_found = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!fill_found && valid_q[w] && sid_q[w] == fl_sid_i && ssid_q[w] == fl_ssid_i
          && va_q[w] == fl_va_i) begin
        fill_way   = WAY_W'(w);
        fill_found = 1'b1;
      end
    end
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!fill_found && !valid_q[w]) begin
        fill_way   = WAY_W'(w);
        fill_found = 1'b1;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      unique case (clr_op_i)
        INV_ALL:      clr_vec[w] = clr_en_i;
        INV_SID:      clr_vec[w] = clr_en_i && clr_sel_i && sid_q[w] == clr_sid_i;
        INV_SID_SSID: clr_vec[w] = clr_en_i && clr_sel_i && sid_q[w] == clr_sid_i
                                   && ssid_q[w] == clr_ssid_i;
        default:      clr_vec[w] = 1'b0;
      endcase
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= 1'b0;
        sid_q[w]   <= '0;
        ssid_q[w]  <= '0;
        va_q[w]    <= '0;
        pa_q[w]    <= '0;
      end else if (clr_vec[w]) begin
        valid_q[w] <= 1'b0;
      end else if (fl_en_i && fill_way == WAY_W'(w)) begin
        valid_q[w] <= 1'b1;
        sid_q[w]   <= fl_sid_i;
        ssid_q[w]  <= fl_ssid_i;
        va_q[w]    <= fl_va_i;
        pa_q[w]    <= fl_pa_i;
      end
    end

    AST_CLR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_en_i && clr_sel_i && clr_op_i == INV_SID_SSID && valid_q[w]
       && sid_q[w] == clr_sid_i && ssid_q[w] == clr_ssid_i) |=> !valid_q[w]); // R6
    AST_CLR_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_en_i && clr_sel_i && clr_op_i == INV_SID && valid_q[w]
       && sid_q[w] == clr_sid_i) |=> !valid_q[w]); // R7
    AST_KEEP_OTHER_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_en_i && clr_op_i == INV_SID && valid_q[w] && sid_q[w] != clr_sid_i
       && !fl_en_i) |=> valid_q[w]); // R7
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R2
  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_op_i == INV_ALL) |=> (valid_q == '0)); // R8
endmodule

// File: rtl/stream_tlb.sv
module stream_tlb
  import stlb_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 2,
  parameter int SID_W    = 8,
  parameter int SSID_W   = 8,
  parameter int VA_W     = 12,
  parameter int PA_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [SID_W-1:0]  lk_sid_i,
  input  logic [SSID_W-1:0] lk_ssid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  output logic              lk_ready_o,
  output logic              lk_resp_valid_o,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_pa_o,
  input  logic              fl_valid_i,
  input  logic [SID_W-1:0]  fl_sid_i,
  input  logic [SSID_W-1:0] fl_ssid_i,
  input  logic [VA_W-1:0]   fl_va_i,
  input  logic [PA_W-1:0]   fl_pa_i,
  output logic              fl_ready_o,
  input  logic              inv_valid_i,
  input  logic [1:0]        inv_op_i,
  input  logic [SID_W-1:0]  inv_sid_i,
  input  logic [SSID_W-1:0] inv_ssid_i,
  output logic              inv_busy_o,
  output logic              inv_done_o
);
  localparam int SET_W = $clog2(NUM_SETS);

  logic              busy;
  inv_op_e           clr_op;
  logic [SET_W-1:0]  clr_set;
  logic [SID_W-1:0]  clr_sid;
  logic [SSID_W-1:0] clr_ssid;
  logic              lk_acc, fl_acc;
  logic [SET_W-1:0]  lk_set, fl_set;
  logic [NUM_SETS-1:0] set_hit;
  logic [PA_W-1:0]   set_pa [NUM_SETS];
  logic              resp_q, hit_q;
  logic [PA_W-1:0]   pa_q;

  stlb_inv_ctrl #(
    .NUM_SETS(NUM_SETS), .SID_W(SID_W), .SSID_W(SSID_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(inv_valid_i),
    .cmd_op_i   (inv_op_i),
    .cmd_sid_i  (inv_sid_i),
    .cmd_ssid_i (inv_ssid_i),
    .busy_o     (busy),
    .done_o     (inv_done_o),
    .clr_op_o   (clr_op),
    .clr_set_o  (clr_set),
    .clr_sid_o  (clr_sid),
    .clr_ssid_o (clr_ssid)
  );

  assign lk_ready_o = !busy;
  assign fl_ready_o = !busy;
  assign inv_busy_o = busy;
  assign lk_acc     = lk_valid_i && !busy;
  assign fl_acc     = fl_valid_i && !busy;
  assign lk_set     = lk_va_i[SET_W-1:0];
  assign fl_set     = fl_va_i[SET_W-1:0];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    stlb_set #(
      .NUM_WAYS(NUM_WAYS), .SID_W(SID_W), .SSID_W(SSID_W), .VA_W(VA_W), .PA_W(PA_W)
    ) u_set (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fl_en_i   (fl_acc && fl_set == SET_W'(s)),
      .fl_sid_i  (fl_sid_i),
      .fl_ssid_i (fl_ssid_i),
      .fl_va_i   (fl_va_i),
      .fl_pa_i   (fl_pa_i),
      .lk_sid_i  (lk_sid_i),
      .lk_ssid_i (lk_ssid_i),
      .lk_va_i   (lk_va_i),
      .lk_hit_o  (set_hit[s]),
      .lk_pa_o   (set_pa[s]),
      .clr_en_i  (busy),
      .clr_sel_i (clr_set == SET_W'(s)),
      .clr_op_i  (clr_op),
      .clr_sid_i (clr_sid),
      .clr_ssid_i(clr_ssid)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= 1'b0;
      hit_q  <= 1'b0;
      pa_q   <= '0;
    end else begin
      resp_q <= lk_acc;
      hit_q  <= lk_acc && set_hit[lk_set];
      pa_q   <= (lk_acc && set_hit[lk_set]) ? set_pa[lk_set] : '0;
    end
  end

  assign lk_resp_valid_o = resp_q;
  assign lk_hit_o        = hit_q;
  assign lk_pa_o         = pa_q;

  AST_NO_RESP_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_resp_valid_o |-> !$past(inv_busy_o)); // R4
  AST_MISS_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_resp_valid_o && !lk_hit_o) |-> (lk_pa_o == '0)); // R3
endmodule

// File: tb/stream_tlb_tb_top.sv
module stream_tlb_tb_top;
  localparam int SETS = 4;
  localparam int WAYS = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lk_valid_i = 1'b0;
  logic [7:0] lk_sid_i = '0, lk_ssid_i = '0;
  logic [11:0] lk_va_i = '0;
  logic lk_ready_o, lk_resp_valid_o, lk_hit_o;
  logic [11:0] lk_pa_o;
  logic fl_valid_i = 1'b0;
  logic [7:0] fl_sid_i = '0, fl_ssid_i = '0;
  logic [11:0] fl_va_i = '0, fl_pa_i = '0;
  logic fl_ready_o;
  logic inv_valid_i = 1'b0;
  logic [1:0] inv_op_i = '0;
  logic [7:0] inv_sid_i = '0, inv_ssid_i = '0;
  logic inv_busy_o, inv_done_o;

  always #10 clk_i = ~clk_i;

  stream_tlb dut_i (.*);

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // reference model
  bit       m_v    [SETS][WAYS];
  int       m_sid  [SETS][WAYS];
  int       m_ssid [SETS][WAYS];
  int       m_va   [SETS][WAYS];
  int       m_pa   [SETS][WAYS];

  typedef struct { logic hit; logic [11:0] pa; string req; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && lk_resp_valid_o) begin
      if (sb_q.size() == 0) begin
        chk(0, "R4 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(lk_hit_o == e.hit, {e.req, " hit"}, lk_hit_o, e.hit);
        chk(lk_pa_o == e.pa, {e.req, " pa"}, lk_pa_o, e.pa);
      end
    end
  end

  task automatic lookup(input int sid, input int ssid, input int va, input string req);
    exp_t e;
    int s;
    @(negedge clk_i);
    s = va % SETS;
    e.hit = 0; e.pa = '0; e.req = req;
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_sid[s][w] == sid && m_ssid[s][w] == ssid && m_va[s][w] == va) begin
        e.hit = 1; e.pa = 12'(m_pa[s][w]);
      end
    sb_q.push_back(e);
    lk_valid_i = 1; lk_sid_i = 8'(sid); lk_ssid_i = 8'(ssid); lk_va_i = 12'(va);
    @(negedge clk_i);
    lk_valid_i = 0;
  endtask

  task automatic fill(input int sid, input int ssid, input int va, input int pa);
    int s, way;
    bit found;
    @(negedge clk_i);
    chk(fl_ready_o == 1, "R4 fill ready when idle", fl_ready_o, 1);
    s = va % SETS; found = 0; way = WAYS - 1;
    for (int w = 0; w < WAYS; w++)
      if (!found && m_v[s][w] && m_sid[s][w] == sid && m_ssid[s][w] == ssid && m_va[s][w] == va) begin
        way = w; found = 1;
      end
    for (int w = 0; w < WAYS; w++)
      if (!found && !m_v[s][w]) begin way = w; found = 1; end
    m_v[s][way] = 1; m_sid[s][way] = sid; m_ssid[s][way] = ssid;
    m_va[s][way] = va; m_pa[s][way] = pa;
    fl_valid_i = 1; fl_sid_i = 8'(sid); fl_ssid_i = 8'(ssid); fl_va_i = 12'(va); fl_pa_i = 12'(pa);
    @(negedge clk_i);
    fl_valid_i = 0;
  endtask

  task automatic command(input int op, input int sid, input int ssid, input int exp_busy,
                         input string req);
    int n;
    @(negedge clk_i);
    inv_valid_i = 1; inv_op_i = 2'(op); inv_sid_i = 8'(sid); inv_ssid_i = 8'(ssid);
    @(negedge clk_i);
    inv_valid_i = 0;
    n = 0;
    while (inv_busy_o) begin
      chk(lk_ready_o == 0 && fl_ready_o == 0, "R4 ready low while busy",
          {lk_ready_o, fl_ready_o}, 0);
      lk_valid_i = 1; lk_sid_i = 8'(sid); lk_ssid_i = 8'(ssid); lk_va_i = '0;
      n++;
      @(negedge clk_i);
    end
    lk_valid_i = 0;
    chk(n == exp_busy, {req, " busy length"}, n, exp_busy);
    chk(inv_done_o == (exp_busy > 0), "R9 done after busy", inv_done_o, exp_busy > 0);
    @(negedge clk_i);
    chk(inv_done_o == 0, "R9 done one cycle", inv_done_o, 0);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        if (op == 3) m_v[s][w] = 0;
        if (op == 2 && m_sid[s][w] == sid) m_v[s][w] = 0;
        if (op == 1 && s == ((sid ^ ssid) % SETS) && m_sid[s][w] == sid && m_ssid[s][w] == ssid)
          m_v[s][w] = 0;
      end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(inv_busy_o == 0 && inv_done_o == 0, "R1 busy/done after reset", {inv_busy_o, inv_done_o}, 0);
    chk(lk_ready_o == 1 && fl_ready_o == 1, "R1 ready after reset", {lk_ready_o, fl_ready_o}, 3);
    lookup(0, 0, 0, "R1 empty miss");
    lookup(1, 2, 'h010, "R1 empty miss");

    // R2 placement, R3 lookup
    fill(1, 2, 'h010, 'hA11);  // set 0 way 0
    fill(1, 3, 'h021, 'hB22);  // set 1
    fill(2, 2, 'h032, 'hC33);  // set 2
    fill(1, 2, 'h003, 'hD44);  // set 3, same pair as first
    lookup(1, 2, 'h010, "R3 hit");
    lookup(1, 3, 'h021, "R3 hit");
    lookup(1, 5, 'h010, "R3 ssid mismatch miss");
    lookup(1, 2, 'h014, "R3 va mismatch miss");
    lookup(3, 2, 'h010, "R3 sid mismatch miss");
    fill(5, 5, 'h040, 'hE55);  // set 0 way 1
    lookup(5, 5, 'h040, "R2 second way");
    fill(6, 6, 'h050, 'hF66);  // set 0 full: last way replaced
    lookup(5, 5, 'h040, "R2 last way evicted");
    lookup(6, 6, 'h050, "R2 new entry in last way");
    lookup(1, 2, 'h010, "R2 way 0 kept");
    fill(1, 2, 'h010, 'h777);  // same tag rewrites way 0
    lookup(1, 2, 'h010, "R2 rewrite same tag");
    lookup(6, 6, 'h050, "R2 rewrite kept other way");

    // R5 no-op
    command(0, 1, 3, 0, "R5 no-op");
    lookup(1, 3, 'h021, "R5 no-op leaves entries");

    // R6 pair invalidate: set (1^2)%4 = 3
    command(1, 1, 2, 1, "R6 pair");
    lookup(1, 2, 'h003, "R6 cleared in xor set");
    lookup(1, 2, 'h010, "R6 other set kept");
    lookup(1, 3, 'h021, "R6 other ssid kept");

    // R7 stream sweep
    command(2, 1, 0, SETS, "R7 stream");
    lookup(1, 2, 'h010, "R7 stream cleared");
    lookup(1, 3, 'h021, "R7 stream cleared any ssid");
    lookup(2, 2, 'h032, "R7 other stream kept");
    lookup(6, 6, 'h050, "R7 other stream kept");

    // R8 all
    command(3, 0, 0, 1, "R8 all");
    lookup(2, 2, 'h032, "R8 all cleared");
    lookup(6, 6, 'h050, "R8 all cleared");

    repeat (3) @(negedge clk_i);
    chk(sb_q.size() == 0, "R3 all responses seen", sb_q.size(), 0);
    report();
  end
endmodule